// File: doc/BRIEF.md
# MDIO Management Master

This block is a station-management master for external PHY devices. It generates the management clock and runs the bidirectional data line, which is modelled as three signals: an output value, an output enable and an input. Software reaches it through a small word-addressed register bus with a write strobe and a combinational read path. It sets a clock divider and the target PHY and register number. It then starts a write by storing the 16-bit write value, or starts a read by taking a command bit from 0 to 1. Completion is found by polling a busy flag and a read-pending flag, and the returned data is read back from a result register.

Each transaction is a 64-bit frame sent MSB first. The frame is 32 preamble ones, the start pattern 01, the opcode (10 for read, 01 for write), the 5-bit PHY address, the 5-bit register number, two turnaround bits and 16 data bits. Data line changes are launched on the falling management-clock edge, which is half a period ahead of the rising edge that the PHY samples. A soft-reset bit in the configuration register aborts any transaction and holds the engine idle.

Top module: `mdio_master`

## Requirements
- R1: Register map on `bus_addr`: 0 = configuration (bit 31 soft reset, bits 3:0 divider), 1 = address (PHY address in bits 12:8, register number in bits 4:0), 2 = write data (bits 15:0), 3 = command (bit 0 read), 4 = read result (bits 15:0), 5 = flags (bit 0 busy, bit 1 read pending). Writing register 2 while idle starts a frame of 32 ones, 01, 01, PHY address, register number, 10 and the 16 data bits, MSB first.
- R2: Writing register 3 with bit 0 = 1 while the stored command bit is 0 starts a read frame with opcode 10. Writing 1 when the stored bit is already 1 starts nothing.
- R3: `mdio_oe` is high for all 64 bits of a write frame. On a read it is high through the first turnaround bit (bit 46) and low from the second turnaround bit (bit 47) to the end of the frame. It is low whenever no frame is running.
- R4: Busy reads 1 in the cycle after the launching write. It returns to 0 on the falling management-clock edge that ends bit 63, so exactly 64 rising edges are produced for each frame.
- R5: Read pending is set when a read launches and cleared when the frame ends. The result register then holds the 16 `mdio_i` values sampled on the rising edges of bits 48 to 63, MSB first.
- R6: The management clock period is 2*(divider+1) system clocks. `mdio_o` changes only on falling edges and stays stable while the clock is high.
- R7: While soft reset is set, any frame is aborted, both flags read 0, `mdc` and `mdio_oe` are low, and writes to registers 2 and 3 are ignored.
- R8: A write to register 2 or 3 while busy is ignored. The stored write value and command bit are unchanged, the running frame goes on unaltered, and no new frame follows.
- R9: After `rst_n` is released, both flags are 0, `mdc` and `mdio_oe` are low, and the configuration register reads back the default divider with soft reset clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Register write value |
| bus_rdata | output | 32 | Read value of the register at `bus_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench acts as a PHY. It records every bit and enable value on the rising edges and drives reply data after falling edges. Against this model it tests divider 0, where each clock phase lasts a single system cycle, so an off-by-one in the half-period counter shows up as a wrong period or a lost sample. It also tests address fields at all zeros and all ones, which would expose a misplaced PHY or register field, and the exact turnaround bit where the enable drops, where a design that releases one bit early or late would fight the PHY or float the bus. Further cases are a repeated command write of 1, which a level-triggered design would turn into a second read. Writes landing mid-frame are checked, since they would corrupt or restart the frame. A soft reset during a read is checked, since a design that got it wrong would leave read pending set or keep clocking.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W   = 4,
  parameter int DEF_DIV = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_W    = 64;
  localparam int DATA_W     = 16;
  localparam int IDX_W      = $clog2(FRAME_W);
  localparam int DATA_START = FRAME_W - DATA_W;
  localparam int TA_REL     = DATA_START - 1;

  localparam logic [2:0] A_CFG = 3'd0, A_ADR = 3'd1, A_WD = 3'd2,
                         A_CMD = 3'd3, A_RES = 3'd4, A_FLG = 3'd5;

  logic              soft_rst, cmd_q, busy, nv, rd_op, phase;
  logic [DIV_W-1:0]  div, hcnt;
  logic [4:0]        phy_ad, reg_ad;
  logic [DATA_W-1:0] wdata, rdata, rx;
  logic [IDX_W-1:0]  idx;
  logic [FRAME_W-1:0] sh;
  logic              unused_hi;

  assign unused_hi = ^bus_wdata[30:DATA_W];

  wire accept = !busy && !soft_rst;
  wire cmd_wr = bus_we && bus_addr == A_CMD && accept;
  wire go_wr  = bus_we && bus_addr == A_WD && accept;
  wire go_rd  = cmd_wr && bus_wdata[0] && !cmd_q;
  wire tick   = busy && hcnt == '0;
  wire last   = idx == IDX_W'(FRAME_W - 1);

  assign mdio_o  = busy ? sh[FRAME_W-1] : 1'b1;
  assign mdio_oe = busy && !(rd_op && idx >= IDX_W'(TA_REL));

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = {soft_rst, {(31-DIV_W){1'b0}}, div};
      A_ADR:   bus_rdata = {19'd0, phy_ad, 3'd0, reg_ad};
      A_WD:    bus_rdata = {16'd0, wdata};
      A_CMD:   bus_rdata = {31'd0, cmd_q};
      A_RES:   bus_rdata = {16'd0, rdata};
      A_FLG:   bus_rdata = {30'd0, nv, busy};
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_rst <= 1'b0;
      div      <= DIV_W'(DEF_DIV);
      phy_ad   <= '0;
      reg_ad   <= '0;
      wdata    <= '0;
      rdata    <= '0;
      rx       <= '0;
      cmd_q    <= 1'b0;
      busy     <= 1'b0;
      nv       <= 1'b0;
      rd_op    <= 1'b0;
      phase    <= 1'b0;
      mdc      <= 1'b0;
      idx      <= '0;
      hcnt     <= '0;
      sh       <= '1;
    end else begin
      if (bus_we && bus_addr == A_CFG) begin
        soft_rst <= bus_wdata[31];
        div      <= bus_wdata[DIV_W-1:0];
      end
      if (bus_we && bus_addr == A_ADR) begin
        phy_ad <= bus_wdata[12:8];
        reg_ad <= bus_wdata[4:0];
      end
      if (go_wr)  wdata <= bus_wdata[DATA_W-1:0];
      if (cmd_wr) cmd_q <= bus_wdata[0];

      if (soft_rst) begin
        busy  <= 1'b0;
        nv    <= 1'b0;
        phase <= 1'b0;
        mdc   <= 1'b0;
        idx   <= '0;
      end else if (go_wr || go_rd) begin
        busy  <= 1'b1;
        nv    <= go_rd;
        rd_op <= go_rd;
        phase <= 1'b0;
        mdc   <= 1'b0;
        idx   <= '0;
        hcnt  <= div;
        sh    <= {32'hFFFF_FFFF, 2'b01, go_rd ? 2'b10 : 2'b01, phy_ad, reg_ad,
                  go_rd ? 2'b11 : 2'b10,
                  go_rd ? 16'hFFFF : bus_wdata[DATA_W-1:0]};
      end else if (tick) begin
        hcnt <= div;
        if (!phase) begin
          phase <= 1'b1;
          mdc   <= 1'b1;
          if (rd_op && idx >= IDX_W'(DATA_START)) rx <= {rx[DATA_W-2:0], mdio_i};
        end else begin
          phase <= 1'b0;
          mdc   <= 1'b0;
          if (last) begin
            busy <= 1'b0;
            if (rd_op) begin
              nv    <= 1'b0;
              rdata <= rx;
            end
          end else begin
            idx <= idx + 1'b1;
            sh  <= {sh[FRAME_W-2:0], 1'b1};
          end
        end
      end else if (busy) begin
        hcnt <= hcnt - 1'b1;
      end
    end
  end
endmodule

module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       nv,
  input logic       soft_rst,
  input logic       cmd_q,
  input logic       bus_we,
  input logic [2:0] bus_addr,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe
);
  assert_oe_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
  assert_launch_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!mdc && mdio_oe));
  assert_end_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !mdc);
  assert_pending_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nv |-> busy);
  assert_stable_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));
  assert_soft_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !nv && !mdc));
  assert_cmd_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && bus_addr == 3'd3) |=> $stable(cmd_q));
endmodule

bind mdio_master mdio_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .nv(nv), .soft_rst(soft_rst),
  .cmd_q(cmd_q), .bus_we(bus_we), .bus_addr(bus_addr), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #10 clk = ~clk;

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int total = 0, fails = 0;
  bit finished = 0;

  // PHY model state
  logic [63:0] cap;
  logic [15:0] resp;
  bit          rd_mode = 0;
  int          nrise = 0, oe_bad = 0, stab_bad = 0, cyc = 0, t0 = 0, t1 = 0;
  logic        mdc_q = 1'b0, last_o = 1'b1;

  initial forever begin
    @(negedge clk);
    cyc++;
    if (mdc && !mdc_q) begin
      cap = {cap[62:0], mdio_o};
      if (mdio_oe !== !(rd_mode && nrise >= 47)) oe_bad++;
      if (nrise == 0) t0 = cyc;
      if (nrise == 1) t1 = cyc;
      nrise++;
    end else if (mdc && mdc_q && mdio_o !== last_o) begin
      stab_bad++;
    end
    if (!mdc && mdc_q && rd_mode && nrise >= 48 && nrise < 64)
      mdio_i = resp[63 - nrise];
    last_o = mdio_o;
    mdc_q  = mdc;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic brd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] f;
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      brd(3'd5, f);
      if (f[0] == 1'b0) begin ok = 1; break; end
    end
  endtask

  task automatic arm(input bit rd, input logic [15:0] r);
    nrise = 0; oe_bad = 0; stab_bad = 0; cap = '0;
    rd_mode = rd; resp = r; mdio_i = 1'b1;
  endtask

  task automatic run(input bit rd, input logic [3:0] dv, input logic [4:0] ph,
                     input logic [4:0] rg, input logic [15:0] d);
    logic [31:0] v;
    logic [63:0] ef;
    bit ok;
    bwr(3'd0, {28'd0, dv});
    bwr(3'd1, {19'd0, ph, 3'd0, rg});
    arm(rd, d);
    if (rd) begin bwr(3'd3, 0); bwr(3'd3, 1); end
    else bwr(3'd2, {16'd0, d});
    brd(3'd5, v);
    chk(v[1:0] == {rd, 1'b1}, rd ? "R5 pending+busy at launch" : "R4 busy at launch",
        v[1:0], {rd, 1'b1});
    wait_idle(ok);
    chk(ok, "R4 frame ends", ok, 1);
    chk(nrise == 64, "R4 rising edge count", nrise, 64);
    chk(t1 - t0 == 2 * (dv + 1), "R6 mdc period", t1 - t0, 2 * (dv + 1));
    chk(stab_bad == 0, "R6 mdio_o stable while mdc high", stab_bad, 0);
    chk(oe_bad == 0, "R3 output enable pattern", oe_bad, 0);
    if (rd) begin
      ef = {32'hFFFF_FFFF, 2'b01, 2'b10, ph, rg, 18'd0};
      chk(cap[63:18] == ef[63:18], "R2 read header", cap, ef);
      brd(3'd4, v);
      chk(v[15:0] == d, "R5 read result", v[15:0], d);
      brd(3'd5, v);
      chk(v[1] == 1'b0, "R5 pending cleared", v[1], 0);
    end else begin
      ef = {32'hFFFF_FFFF, 2'b01, 2'b01, ph, rg, 2'b10, d};
      chk(cap == ef, "R1 write frame", cap, ef);
    end
  endtask

  // {rd, div[3:0], phy[4:0], reg[4:0], data[15:0]}
  localparam logic [30:0] VEC [6] = '{
    {1'b0, 4'd1, 5'd3,  5'd17, 16'hA5C3},
    {1'b1, 4'd1, 5'd3,  5'd17, 16'h1E2D},
    {1'b0, 4'd0, 5'd0,  5'd0,  16'hFFFF},
    {1'b1, 4'd0, 5'd31, 5'd31, 16'h8001},
    {1'b0, 4'd3, 5'd31, 5'd31, 16'h0000},
    {1'b1, 4'd2, 5'd16, 5'd1,  16'hFFFF}
  };

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    brd(3'd5, v);
    chk(v[1:0] == 0, "R9 flags after reset", v, 0);
    chk(!mdc && !mdio_oe, "R9 pins idle", {mdc, mdio_oe}, 0);
    brd(3'd0, v);
    chk(v == 32'd1, "R9 config default", v, 1);

    foreach (VEC[i]) run(VEC[i][30], VEC[i][29:26], VEC[i][25:21], VEC[i][20:16], VEC[i][15:0]);

    // R2: command already 1, writing 1 again starts nothing
    bwr(3'd3, 1);
    brd(3'd5, v);
    chk(v[0] == 0, "R2 no relaunch on held bit", v[0], 0);

    // R8: writes during a frame are ignored
    bwr(3'd3, 0);
    bwr(3'd0, 32'd1);
    bwr(3'd1, {19'd0, 5'd9, 3'd0, 5'd4});
    arm(0, 0);
    bwr(3'd2, 32'h0000_3C5A);
    repeat (20) @(negedge clk);
    bwr(3'd2, 32'h0000_FFFF);
    bwr(3'd3, 1);
    brd(3'd3, v);
    chk(v[0] == 0, "R8 command unchanged while busy", v[0], 0);
    brd(3'd2, v);
    chk(v[15:0] == 16'h3C5A, "R8 write value unchanged while busy", v[15:0], 16'h3C5A);
    brd(3'd5, v);
    chk(v[1:0] == 2'b01, "R8 flags unchanged while busy", v[1:0], 2'b01);
    wait_idle(ok);
    chk(cap == {32'hFFFF_FFFF, 4'b0101, 5'd9, 5'd4, 2'b10, 16'h3C5A}, "R8 frame unaltered",
        cap, {32'hFFFF_FFFF, 4'b0101, 5'd9, 5'd4, 2'b10, 16'h3C5A});
    repeat (10) @(negedge clk);
    brd(3'd5, v);
    chk(v[0] == 0 && nrise == 64, "R8 no frame follows", {v[0], 32'(nrise)}, 64);

    // R7: soft reset during a read
    arm(1, 16'h5555);
    bwr(3'd3, 1);
    repeat (50) @(negedge clk);
    bwr(3'd0, 32'h8000_0001);
    @(negedge clk);
    brd(3'd5, v);
    chk(v[1:0] == 0, "R7 flags cleared by soft reset", v[1:0], 0);
    chk(!mdc && !mdio_oe, "R7 pins idle in soft reset", {mdc, mdio_oe}, 0);
    bwr(3'd2, 32'h1234);
    bwr(3'd3, 0);
    brd(3'd5, v);
    chk(v[0] == 0 && !mdc, "R7 launch ignored in soft reset", v[0], 0);
    brd(3'd3, v);
    chk(v[0] == 1, "R7 command write ignored in soft reset", v[0], 1);
    bwr(3'd0, 32'd1);
    bwr(3'd3, 0);
    run(1, 4'd1, 5'd7, 5'd2, 16'hC0DE);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule